// File: doc/BRIEF.md
# Dual-channel storage I/O decoder

This block sits between a host I/O port and the register files of a two-channel storage controller. Five windows can be hit in the I/O space: a command window and a control window for each channel, and one bus-master window that both channels share. For each request, the decoder picks the window that the address falls into, checks the access size, and applies the global I/O-enable and bus-master-enable gates. It then drives a one-hot target select together with the offset inside the target's register set. Every window base can be loaded at run time.

Each channel holds up to two drives, so the block serves up to four. The decoder watches writes to the drive-select location of each command window and keeps a record of which drive is current on each channel. A command or control access to a drive position with no device is answered at once with zero data. The bus-master window is split in two. Its lower half serves channel 0. Its upper half serves channel 1 and is rebased to start at offset zero. The primary channel has two offset adjustments: its command offsets can be shifted right, and its control offsets can have a constant added.

Top module: `stio_io_decode`

## Requirements
- R1: A request whose size is not 1, 2 or 4 bytes raises `err_size`. It selects no target and changes no drive selection.
- R2: When `io_en` is low, a request of legal size raises `zero_ack`. It selects no target and leaves both drive selections unchanged.
- R3: Windows are tried in a fixed order: primary command (bit 0), primary control (bit 1), secondary command (bit 2), secondary control (bit 3), then bus-master. An enabled request of legal size that hits no window raises `err_addr`.
- R4: A write to the bus-master window while `bm_en` is low raises `zero_ack` and selects no target. Reads of that window are forwarded whatever the state of `bm_en`.
- R5: A bus-master offset below half the window span (8 by default) selects target bit 4 with that offset. A higher offset selects target bit 5 with the offset minus half the span.
- R6: A forwarded write to command offset 6 of a channel loads data bit 4 as that channel's drive selection, visible on `drv_sel` from the next cycle. The access itself already uses the new value on `tgt_drive`.
- R7: `drv_present[2*channel+drive]` tells whether a drive position has a device. A command or control access to an empty position raises `zero_ack` if it is a byte access and `err_size` otherwise, and selects no target.
- R8: The primary command offset is (address − base) shifted right by `PRI_CMD_SHIFT` (default 1). The primary control offset is (address − base) + `PRI_CTL_ADD` (default 2). Offsets on the secondary channel are not adjusted.
- R9: A pulse on `base_we` loads `base_wdata` into the base chosen by `base_sel`: 0 primary command, 1 primary control, 2 secondary command, 3 secondary control, 4 bus-master. A value of zero leaves the old base in place.
- R10: `tgt_sel` has six bits: bits 0–3 follow the window order of R3, bit 4 is the channel 0 bus-master registers, bit 5 is the channel 1 bus-master registers. `tgt_sel` is one-hot or zero. Each request gives exactly one outcome: a forwarded target, `zero_ack`, `err_addr` or `err_size`.
- R11: After reset every base is zero and both drive selections are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | I/O decoding enable |
| bm_en | input | 1 | Bus-master write enable |
| drv_present | input | 4 | Device present, index 2*channel+drive |
| base_we | input | 1 | Base load strobe |
| base_sel | input | 3 | Base index (R9) |
| base_wdata | input | AW (16) | New base value |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes |
| req_addr | input | AW (16) | I/O address |
| req_wdata | input | DW (32) | Write data |
| tgt_sel | output | 6 | One-hot target select (R10) |
| tgt_offset | output | OFF_W (8) | Adjusted local offset |
| tgt_drive | output | 1 | Drive in use on the target channel |
| tgt_write | output | 1 | Forwarded direction |
| tgt_size | output | 3 | Forwarded size |
| tgt_wdata | output | DW (32) | Forwarded write data |
| drv_sel | output | 2 | Drive selection per channel |
| zero_ack | output | 1 | Completed here with zero read data |
| err_addr | output | 1 | No window hit |
| err_size | output | 1 | Illegal access size |

## Verification
The assertions assume that every input holds a known value at each sampled edge. They also assume that a request, together with its write data, stays stable through the edge that would load a drive selection. To meet this, the bench drives every input half a cycle away from the rising edge and holds it for a full cycle. In the random phase the window bases are kept apart, so that each window's own decode is exercised. The priority order is tested by directed requests made while every base is still zero and all windows overlap.

// File: rtl/stio_pkg.sv
package stio_pkg;

  localparam int NWIN = 5;
  localparam int NTGT = 6;

  localparam int W_P_CMD = 0;
  localparam int W_P_CTL = 1;
  localparam int W_S_CMD = 2;
  localparam int W_S_CTL = 3;
  localparam int W_BM    = 4;

  localparam int T_BM0 = 4;
  localparam int T_BM1 = 5;

  localparam int DRV_SEL_OFF = 6;
  localparam int DRV_SEL_BIT = 4;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

endpackage

// File: rtl/stio_base_bank.sv
module stio_base_bank
  import stio_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_idx,
  input  logic [AW-1:0]            wr_val,
  output logic [NWIN-1:0][AW-1:0]  base_o
);

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [AW-1:0] q;
    logic [AW-1:0] d;
    logic          ld;

    assign ld = wr_en && (wr_idx == 3'(i)) && (wr_val != '0);

    always_comb begin
      d = q;
      if (ld) d = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign base_o[i] = q;
  end

endmodule

// File: rtl/stio_win_match.sv
module stio_win_match
  import stio_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CMD_SPAN = 16,
  parameter int CTL_SPAN = 4,
  parameter int BM_SPAN  = 16
) (
  input  logic [AW-1:0]            addr,
  input  logic [NWIN-1:0][AW-1:0]  base,
  output logic [NWIN-1:0]          hit,
  output logic [NWIN-1:0][AW-1:0]  rel
);

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    localparam int SPAN = (i == W_BM) ? BM_SPAN :
                          ((i == W_P_CTL) || (i == W_S_CTL)) ? CTL_SPAN : CMD_SPAN;
    localparam logic [AW-1:0] SPAN_V = AW'(SPAN);

    assign rel[i] = addr - base[i];
    assign hit[i] = (addr >= base[i]) && (rel[i] < SPAN_V);
  end

endmodule

// File: rtl/stio_drive_track.sv
module stio_drive_track #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] upd,
  input  logic [NCH-1:0] val,
  output logic [NCH-1:0] cur
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic q;
    logic d;

    always_comb begin
      d = q;
      if (upd[c]) d = val[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end

    assign cur[c] = q;
  end

endmodule

// File: rtl/stio_io_decode.sv
module stio_io_decode
  import stio_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 32,
  parameter int OFF_W         = 8,
  parameter int CMD_SPAN      = 16,
  parameter int CTL_SPAN      = 4,
  parameter int BM_SPAN       = 16,
  parameter int PRI_CMD_SHIFT = 1,
  parameter int PRI_CTL_ADD   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_en,
  input  logic             bm_en,
  input  logic [3:0]       drv_present,
  input  logic             base_we,
  input  logic [2:0]       base_sel,
  input  logic [AW-1:0]    base_wdata,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [2:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic [5:0]       tgt_sel,
  output logic [OFF_W-1:0] tgt_offset,
  output logic             tgt_drive,
  output logic             tgt_write,
  output logic [2:0]       tgt_size,
  output logic [DW-1:0]    tgt_wdata,
  output logic [1:0]       drv_sel,
  output logic             zero_ack,
  output logic             err_addr,
  output logic             err_size
);

  localparam int NCH = 2;
  localparam int BM_CH_SPAN = BM_SPAN / 2;
  localparam logic [AW-1:0] BM_HALF = AW'(BM_CH_SPAN);
  localparam logic [AW-1:0] SEL_OFF = AW'(DRV_SEL_OFF);

  logic [NWIN-1:0][AW-1:0] base_q;
  logic [NWIN-1:0]         hit;
  logic [NWIN-1:0][AW-1:0] rel;
  logic [NWIN-1:0]         win_oh;

  stio_base_bank #(.AW(AW)) u_bases (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (base_we),
    .wr_idx (base_sel),
    .wr_val (base_wdata),
    .base_o (base_q)
  );

  stio_win_match #(
    .AW(AW), .CMD_SPAN(CMD_SPAN), .CTL_SPAN(CTL_SPAN), .BM_SPAN(BM_SPAN)
  ) u_match (
    .addr (req_addr),
    .base (base_q),
    .hit  (hit),
    .rel  (rel)
  );

  // fixed-priority pick among overlapping windows
  always_comb begin
    logic found;
    found  = 1'b0;
    win_oh = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (hit[i] && !found) begin
        win_oh[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  logic          any_hit, is_bm, bm_hi, is_cmd, is_drvwin, ch_idx;
  logic [AW-1:0] bm_rel, off_full;

  assign any_hit   = |hit;
  assign is_bm     = win_oh[W_BM];
  assign bm_rel    = rel[W_BM];
  assign bm_hi     = is_bm && (bm_rel >= BM_HALF);
  assign is_cmd    = win_oh[W_P_CMD] | win_oh[W_S_CMD];
  assign is_drvwin = |win_oh[W_S_CTL:W_P_CMD];
  assign ch_idx    = win_oh[W_S_CMD] | win_oh[W_S_CTL] | bm_hi;

  always_comb begin
    if (win_oh[W_P_CMD])      off_full = rel[W_P_CMD] >> PRI_CMD_SHIFT;
    else if (win_oh[W_P_CTL]) off_full = rel[W_P_CTL] + AW'(PRI_CTL_ADD);
    else if (win_oh[W_S_CMD]) off_full = rel[W_S_CMD];
    else if (win_oh[W_S_CTL]) off_full = rel[W_S_CTL];
    else if (bm_hi)           off_full = bm_rel - BM_HALF;
    else                      off_full = bm_rel;
  end

  // request qualification and drive-select snoop
  logic           sz_ok, legal, snoop, eff_drv, present;
  logic [NCH-1:0] sel_upd, sel_val;

  assign sz_ok   = size_legal(req_size);
  assign legal   = req_valid && sz_ok && io_en;
  assign snoop   = legal && is_cmd && req_write && (off_full == SEL_OFF);
  assign sel_upd = snoop ? (NCH'(1) << ch_idx) : '0;
  assign sel_val = {NCH{req_wdata[DRV_SEL_BIT]}};

  stio_drive_track #(.NCH(NCH)) u_drv (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (sel_upd),
    .val   (sel_val),
    .cur   (drv_sel)
  );

  assign eff_drv = snoop ? req_wdata[DRV_SEL_BIT] : drv_sel[ch_idx];
  assign present = drv_present[{ch_idx, eff_drv}];

  // outcome classification
  logic size_bad, io_off, bm_block, absent, is_byte, fwd;
  logic [5:0] tgt_oh;

  assign size_bad = req_valid && !sz_ok;
  assign io_off   = req_valid && sz_ok && !io_en;
  assign bm_block = legal && is_bm && req_write && !bm_en;
  assign absent   = legal && is_drvwin && !present;
  assign is_byte  = (req_size == 3'd1);
  assign fwd      = legal && any_hit && !bm_block && !absent;

  assign tgt_oh = {is_bm && bm_hi, is_bm && !bm_hi, win_oh[W_S_CTL:W_P_CMD]};

  assign tgt_sel    = fwd ? tgt_oh : '0;
  assign tgt_offset = off_full[OFF_W-1:0];
  assign tgt_drive  = eff_drv;
  assign tgt_write  = req_write;
  assign tgt_size   = req_size;
  assign tgt_wdata  = req_wdata;

  assign zero_ack = io_off || bm_block || (absent && is_byte);
  assign err_addr = legal && !any_hit;
  assign err_size = size_bad || (absent && !is_byte);

endmodule

// File: rtl/stio_io_decode_chk.sv
module stio_io_decode_chk #(
  parameter int OFF_W      = 8,
  parameter int BM_CH_SPAN = 8,
  parameter int DW         = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_en,
  input logic             bm_en,
  input logic             req_valid,
  input logic             req_write,
  input logic [2:0]       req_size,
  input logic [5:0]       tgt_sel,
  input logic [OFF_W-1:0] tgt_offset,
  input logic             tgt_write,
  input logic [DW-1:0]    tgt_wdata,
  input logic [1:0]       drv_sel,
  input logic             zero_ack,
  input logic             err_addr,
  input logic             err_size
);

  p_onehot_tgt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({|tgt_sel, zero_ack, err_addr, err_size}));

  p_size_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4))
      |-> (err_size && tgt_sel == 6'd0));

  p_io_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !io_en) |-> (tgt_sel == 6'd0 && !err_addr));

  p_bm_wr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !bm_en) |-> (tgt_sel[5:4] == 2'b00));

  p_bm_off_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|tgt_sel[5:4]) |-> (tgt_offset < OFF_W'(BM_CH_SPAN)));

  p_drv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && io_en) |=> $stable(drv_sel));

  p_drv_latch_p_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel[0] && tgt_write && tgt_offset == OFF_W'(6))
      |=> (drv_sel[0] == $past(tgt_wdata[4])));

  p_drv_latch_s_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel[2] && tgt_write && tgt_offset == OFF_W'(6))
      |=> (drv_sel[1] == $past(tgt_wdata[4])));

endmodule

bind stio_io_decode stio_io_decode_chk #(
  .OFF_W(OFF_W), .BM_CH_SPAN(BM_SPAN / 2), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
  .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
  .tgt_sel(tgt_sel), .tgt_offset(tgt_offset), .tgt_write(tgt_write),
  .tgt_wdata(tgt_wdata), .drv_sel(drv_sel), .zero_ack(zero_ack),
  .err_addr(err_addr), .err_size(err_size)
);

// File: tb/stio_io_decode_tb.sv
`timescale 1ns/1ps
module stio_io_decode_tb;

  logic        clk, rst_n, io_en, bm_en, base_we, req_valid, req_write;
  logic [3:0]  drv_present;
  logic [2:0]  base_sel, req_size, tgt_size;
  logic [15:0] base_wdata, req_addr;
  logic [31:0] req_wdata, tgt_wdata;
  logic [5:0]  tgt_sel;
  logic [7:0]  tgt_offset;
  logic        tgt_drive, tgt_write, zero_ack, err_addr, err_size;
  logic [1:0]  drv_sel;

  stio_io_decode u_dut (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
    .drv_present(drv_present), .base_we(base_we), .base_sel(base_sel),
    .base_wdata(base_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .tgt_sel(tgt_sel), .tgt_offset(tgt_offset), .tgt_drive(tgt_drive),
    .tgt_write(tgt_write), .tgt_size(tgt_size), .tgt_wdata(tgt_wdata),
    .drv_sel(drv_sel), .zero_ack(zero_ack), .err_addr(err_addr),
    .err_size(err_size)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [15:0] mb [5];
  logic        md [2];

  // expected outputs
  logic [5:0] e_sel;
  logic [7:0] e_off;
  logic       e_drv, e_zero, e_ea, e_es;

  function automatic int span_of(input int i);
    if (i == 4) return 16;
    if (i == 1 || i == 3) return 4;
    return 16;
  endfunction

  task automatic model(input logic [15:0] a, input logic [2:0] sz, input logic wr,
                       input logic [31:0] wd, input logic io, input logic bm,
                       input logic [3:0] dp);
    int w;
    logic [15:0] r;
    logic ch, d;
    w = -1;
    e_sel = '0; e_off = '0; e_drv = 1'b0; e_zero = 1'b0; e_ea = 1'b0; e_es = 1'b0;
    for (int i = 0; i < 5; i++)
      if (w < 0 && a >= mb[i] && (a - mb[i]) < 16'(span_of(i))) w = i;
    if (!(sz == 3'd1 || sz == 3'd2 || sz == 3'd4)) e_es = 1'b1;
    else if (!io) e_zero = 1'b1;
    else if (w < 0) e_ea = 1'b1;
    else if (w == 4) begin
      r = a - mb[4];
      ch = (r >= 16'd8);
      e_off = ch ? 8'(r - 16'd8) : 8'(r);
      if (wr && !bm) e_zero = 1'b1;
      else e_sel = ch ? 6'b100000 : 6'b010000;
    end else begin
      r = a - mb[w];
      ch = (w >= 2);
      if (w == 0) r = r >> 1;
      else if (w == 1) r = r + 16'd2;
      e_off = 8'(r);
      d = md[ch];
      if ((w == 0 || w == 2) && wr && r == 16'd6) begin
        d = wd[4];
        md[ch] = d;
      end
      e_drv = d;
      if (!dp[{ch, d}]) begin
        if (sz == 3'd1) e_zero = 1'b1;
        else e_es = 1'b1;
      end else e_sel = 6'(1) << w;
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] a, input logic [2:0] sz,
                       input logic wr, input logic [31:0] wd, input logic io,
                       input logic bm, input logic [3:0] dp);
    logic ok;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = wd; io_en = io; bm_en = bm; drv_present = dp;
    #5;
    model(a, sz, wr, wd, io, bm, dp);
    ok = (tgt_sel == e_sel) && (zero_ack == e_zero) && (err_addr == e_ea) &&
         (err_size == e_es);
    if (e_sel != 0) ok = ok && (tgt_offset == e_off) && (tgt_write == wr);
    if (e_sel[3:0] != 0) ok = ok && (tgt_drive == e_drv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s addr=%h actual sel=%b off=%h drv=%b z=%b ea=%b es=%b expected sel=%b off=%h drv=%b z=%b ea=%b es=%b",
               tag, a, tgt_sel, tgt_offset, tgt_drive, zero_ack, err_addr, err_size,
               e_sel, e_off, e_drv, e_zero, e_ea, e_es);
    end
  endtask

  task automatic check_drv(input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    #5;
    checks++;
    if (drv_sel != {md[1], md[0]}) begin
      fails++;
      $display("FAIL %s drv_sel actual=%b expected=%b", tag, drv_sel, {md[1], md[0]});
    end
  endtask

  task automatic set_base(input logic [2:0] idx, input logic [15:0] v);
    @(negedge clk);
    req_valid = 1'b0;
    base_we = 1'b1; base_sel = idx; base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
    if (idx < 3'd5 && v != 16'd0) mb[idx] = v;
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    checks++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] wbase [6];
    void'($urandom(32'd2024));
    rst_n = 1'b0; io_en = 1'b0; bm_en = 1'b0; drv_present = 4'hF;
    base_we = 1'b0; base_sel = '0; base_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_size = 3'd1; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < 5; i++) mb[i] = '0;
    md[0] = 1'b0; md[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    check_drv("R11");
    // R3: all bases zero, all windows overlap, primary command wins
    apply("R3", 16'h0000, 3'd1, 1'b0, 32'h0, 1'b1, 1'b1, 4'hF);
    apply("R3", 16'h0003, 3'd2, 1'b0, 32'h0, 1'b1, 1'b1, 4'hF);

    // R9: program bases, zero write ignored
    set_base(3'd0, 16'h0100);
    set_base(3'd1, 16'h0200);
    set_base(3'd2, 16'h0300);
    set_base(3'd3, 16'h0400);
    set_base(3'd4, 16'h0500);
    set_base(3'd0, 16'h0000);
    apply("R9", 16'h0104, 3'd1, 1'b0, 32'h0, 1'b1, 1'b1, 4'hF);
    apply("R9", 16'h0402, 3'd1, 1'b0, 32'h0, 1'b1, 1'b1, 4'hF);

    // R1: illegal size
    apply("R1", 16'h0300, 3'd3, 1'b0, 32'h0, 1'b1, 1'b1, 4'hF);
    apply("R1", 16'h0306, 3'd0, 1'b1, 32'h10, 1'b1, 1'b1, 4'hF);
    check_drv("R1");

    // R2: I/O disabled, drive-select write has no effect
    apply("R2", 16'h0306, 3'd1, 1'b1, 32'h10, 1'b0, 1'b1, 4'hF);
    check_drv("R2");

    // R6: secondary drive select
    apply("R6", 16'h0306, 3'd1, 1'b1, 32'h10, 1'b1, 1'b1, 4'hF);
    check_drv("R6");

    // R8: primary command shift, select write at shifted offset 6
    apply("R8", 16'h010C, 3'd1, 1'b1, 32'h10, 1'b1, 1'b1, 4'hF);
    check_drv("R6");
    apply("R8", 16'h0201, 3'd2, 1'b0, 32'h0, 1'b1, 1'b1, 4'hF);
    apply("R8", 16'h0303, 3'd4, 1'b0, 32'h0, 1'b1, 1'b1, 4'hF);

    // R7: channel 1 drive 1 absent
    apply("R7", 16'h0401, 3'd1, 1'b0, 32'h0, 1'b1, 1'b1, 4'b0111);
    apply("R7", 16'h0401, 3'd2, 1'b0, 32'h0, 1'b1, 1'b1, 4'b0111);
    apply("R7", 16'h0306, 3'd1, 1'b1, 32'h00, 1'b1, 1'b1, 4'b0111);
    check_drv("R7");

    // R4: bus-master gate
    apply("R4", 16'h0502, 3'd1, 1'b1, 32'h1, 1'b1, 1'b0, 4'hF);
    apply("R4", 16'h0502, 3'd1, 1'b0, 32'h0, 1'b1, 1'b0, 4'hF);

    // R5: bus-master split
    apply("R5", 16'h050A, 3'd4, 1'b0, 32'h0, 1'b1, 1'b1, 4'hF);
    apply("R5", 16'h0507, 3'd1, 1'b1, 32'h0, 1'b1, 1'b1, 4'hF);

    // R3: address outside every window
    apply("R3", 16'h0050, 3'd1, 1'b0, 32'h0, 1'b1, 1'b1, 4'hF);
    apply("R3", 16'h0204, 3'd1, 1'b0, 32'h0, 1'b1, 1'b1, 4'hF);

    // R10: random mix
    wbase[0] = 16'h0100; wbase[1] = 16'h0200; wbase[2] = 16'h0300;
    wbase[3] = 16'h0400; wbase[4] = 16'h0500; wbase[5] = 16'h0050;
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [2:0]  sz;
      logic [3:0]  dp;
      int k;
      k  = int'($urandom_range(0, 5));
      a  = wbase[k] + 16'($urandom_range(0, 19));
      case ($urandom_range(0, 7))
        0: sz = 3'($urandom_range(0, 7));
        1, 2: sz = 3'd2;
        3: sz = 3'd4;
        default: sz = 3'd1;
      endcase
      dp = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      apply("R10", a, sz, 1'($urandom), $urandom,
            $urandom_range(0, 9) != 0, $urandom_range(0, 9) > 2, dp);
      if (n % 50 == 0) check_drv("R6");
    end
    check_drv("R6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule